// File: doc/BRIEF.md
# Hysteretic Temperature Event Filter

This block turns a stream of signed temperature readings into qualified threshold events for several independent zones. Each zone has a high set-point and a lower release threshold. A zone reports an over-temperature event only after the required number of consecutive readings lie above the set-point. It then waits for the same number of consecutive readings below the release threshold and reports an under-temperature event. Because the zone only ever waits for the opposite crossing, a temperature that stays high produces one event, not one event per reading.

The consecutive-reading count is chosen by a two-bit depth code that is shared by all zones. This code trades noise rejection against detection latency: an event is detected no earlier than depth times the reading period. Each event is a single-clock pulse with a direction bit. A level output per zone follows the most recent event, which gives comparator-style behaviour. A shutdown input stops all evaluation and returns every zone to its idle state. Readings arrive with a per-zone valid strobe. Thresholds and depth are static configuration inputs.

Top module: `thermal_event_filter`

## Requirements
- R1: The depth code selects the number of consecutive qualifying readings needed for an event: code 00 needs 1, 01 needs 2, 10 needs 4 and 11 needs 6.
- R2: While a zone waits for an over-temperature event, a reading qualifies only if it is strictly greater than that zone's set-point. A reading equal to the set-point does not qualify.
- R3: A valid reading that does not qualify for the awaited condition clears that zone's consecutive count to zero. Clock cycles without a valid strobe for the zone leave its state unchanged.
- R4: After an over-temperature event the zone waits only for an under-temperature event, and the reverse holds after an under-temperature event. An under-temperature reading qualifies only if it is strictly less than the release threshold. The level output goes to 1 on an over event and to 0 on an under event.
- R5: An event appears on evt_pulse for exactly one clock, in the cycle after the clock edge that captured the qualifying reading. In that cycle evt_dir is 1 for an over event and 0 for an under event.
- R6: Each zone keeps its own count, awaited condition and level. A reading for one zone never changes another zone's outputs.
- R7: While shutdown is 1, valid readings are ignored and no events are produced. At every clock edge with shutdown high, each zone clears its count and its level and waits for an over-temperature event.
- R8: After reset every zone has level 0 and evt_pulse 0, and waits for an over-temperature event.
- R9: Readings and thresholds are compared as 8-bit two's-complement numbers. Zone z uses bits [8z+7:8z] of each packed bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shutdown | input | 1 | 1 stops evaluation and idles all zones |
| depth_code | input | 2 | Consecutive-reading depth selector |
| smp_valid | input | 3 | Per-zone reading strobe |
| smp_bus | input | 24 | Packed signed readings, 8 bits per zone |
| set_bus | input | 24 | Packed signed set-points |
| hyst_bus | input | 24 | Packed signed release thresholds |
| evt_pulse | output | 3 | Per-zone one-clock event pulse |
| evt_dir | output | 3 | Per-zone event direction, 1 = over |
| level | output | 3 | Per-zone comparator-style level |

## Verification
The hardest situation to reach is a deep-filter run that breaks one reading short of the target. At depth six, five readings qualify and the sixth does not. A full run of six qualifying readings must then follow before the event may fire. The stimulus builds this run on purpose. It also sets readings exactly equal to each threshold and interleaves strobes for different zones. A long pseudo-random phase places readings close to the thresholds, changes the depth code now and then, and raises shutdown briefly. All of this is compared cycle by cycle against a behavioural model.

// File: rtl/thermfilt_pkg.sv
package thermfilt_pkg;
    localparam int CNT_W = 3;

    typedef enum logic {
        ARM_UNDER = 1'b0,
        ARM_OVER  = 1'b1
    } arm_e;

    typedef struct packed {
        arm_e             arm;
        logic [CNT_W-1:0] cnt;
        logic             level;
        logic             pulse;
        logic             dir;
    } zone_st_t;

    localparam zone_st_t ZONE_IDLE = '{arm: ARM_OVER, cnt: '0, level: 1'b0, pulse: 1'b0, dir: 1'b0};

    function automatic logic [CNT_W-1:0] depth_of(input logic [1:0] code);
        case (code)
            2'b00:   return CNT_W'(1);
            2'b01:   return CNT_W'(2);
            2'b10:   return CNT_W'(4);
            default: return CNT_W'(6);
        endcase
    endfunction
endpackage

// File: rtl/depth_decode.sv
module depth_decode
    import thermfilt_pkg::*;
(
    input  logic [1:0]       depth_code,
    output logic [CNT_W-1:0] need
);
    always_comb begin
        need = depth_of(depth_code);
    end
endmodule

// File: rtl/thr_compare.sv
module thr_compare #(
    parameter int TEMP_W = 8
) (
    input  logic [TEMP_W-1:0] smp,
    input  logic [TEMP_W-1:0] set_pt,
    input  logic [TEMP_W-1:0] hyst,
    input  logic              want_over,
    output logic              qual
);
    logic signed [TEMP_W-1:0] s_smp, s_set, s_hyst;

    always_comb begin
        s_smp  = $signed(smp);
        s_set  = $signed(set_pt);
        s_hyst = $signed(hyst);
        qual   = want_over ? (s_smp > s_set) : (s_smp < s_hyst);
    end
endmodule

// File: rtl/zone_filter.sv
module zone_filter
    import thermfilt_pkg::*;
#(
    parameter int TEMP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shutdown,
    input  logic              smp_valid,
    input  logic [TEMP_W-1:0] smp,
    input  logic [TEMP_W-1:0] set_pt,
    input  logic [TEMP_W-1:0] hyst,
    input  logic [CNT_W-1:0]  need,
    output logic              evt_pulse,
    output logic              evt_dir,
    output logic              level
);
    zone_st_t         st_d, st_q;
    logic             qual;
    logic [CNT_W-1:0] cnt_inc;

    thr_compare #(.TEMP_W(TEMP_W)) u_cmp (
        .smp       (smp),
        .set_pt    (set_pt),
        .hyst      (hyst),
        .want_over (st_q.arm == ARM_OVER),
        .qual      (qual)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        cnt_inc    = st_q.cnt + CNT_W'(1);
        if (shutdown) begin
            st_d = ZONE_IDLE;
        end else if (smp_valid) begin
            if (!qual) begin
                st_d.cnt = '0;
            end else if (cnt_inc >= need) begin
                st_d.cnt   = '0;
                st_d.pulse = 1'b1;
                st_d.dir   = (st_q.arm == ARM_OVER);
                st_d.level = (st_q.arm == ARM_OVER);
                st_d.arm   = (st_q.arm == ARM_OVER) ? ARM_UNDER : ARM_OVER;
            end else begin
                st_d.cnt = cnt_inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ZONE_IDLE;
        else        st_q <= st_d;
    end

    assign evt_pulse = st_q.pulse;
    assign evt_dir   = st_q.dir;
    assign level     = st_q.level;

    // R1: the count never reaches the largest depth
    p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(5));

    // R3: no strobe means no event at the next edge
    p_no_strobe_no_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> !evt_pulse);

    // R4: every event flips the level, and the direction equals the new level
    p_level_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        evt_pulse |-> (level != $past(level)) && (evt_dir == level));

    // R7: shutdown silences the zone and clears its level
    p_shutdown_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |=> !evt_pulse && !level);
endmodule

// File: rtl/thermal_event_filter.sv
module thermal_event_filter
    import thermfilt_pkg::*;
#(
    parameter int NUM_ZONES = 3,
    parameter int TEMP_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        shutdown,
    input  logic [1:0]                  depth_code,
    input  logic [NUM_ZONES-1:0]        smp_valid,
    input  logic [NUM_ZONES*TEMP_W-1:0] smp_bus,
    input  logic [NUM_ZONES*TEMP_W-1:0] set_bus,
    input  logic [NUM_ZONES*TEMP_W-1:0] hyst_bus,
    output logic [NUM_ZONES-1:0]        evt_pulse,
    output logic [NUM_ZONES-1:0]        evt_dir,
    output logic [NUM_ZONES-1:0]        level
);
    logic [CNT_W-1:0] need;

    depth_decode u_depth (
        .depth_code (depth_code),
        .need       (need)
    );

    // R6: one fully independent filter per zone
    for (genvar z = 0; z < NUM_ZONES; z++) begin : g_zone
        zone_filter #(.TEMP_W(TEMP_W)) u_zone (
            .clk       (clk),
            .rst_n     (rst_n),
            .shutdown  (shutdown),
            .smp_valid (smp_valid[z]),
            .smp       (smp_bus[z*TEMP_W +: TEMP_W]),
            .set_pt    (set_bus[z*TEMP_W +: TEMP_W]),
            .hyst      (hyst_bus[z*TEMP_W +: TEMP_W]),
            .need      (need),
            .evt_pulse (evt_pulse[z]),
            .evt_dir   (evt_dir[z]),
            .level     (level[z])
        );
    end

    // R6: a zone without a strobe produces no event
    p_zone_isolated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (evt_pulse & ~$past(smp_valid)) == '0);
endmodule

// File: tb/thermal_event_filter_bench.sv
module thermal_event_filter_bench;
    localparam int NZ = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          shutdown = 1'b0;
    logic [1:0]    depth_code = 2'b00;
    logic [NZ-1:0] smp_valid = '0;
    logic [7:0]    smp_v [NZ];
    logic [7:0]    set_v [NZ];
    logic [7:0]    hyst_v [NZ];
    logic [NZ*8-1:0] smp_bus, set_bus, hyst_bus;
    logic [NZ-1:0] evt_pulse, evt_dir, level;

    always #4 clk = ~clk;

    for (genvar z = 0; z < NZ; z++) begin : g_pack
        assign smp_bus[z*8 +: 8]  = smp_v[z];
        assign set_bus[z*8 +: 8]  = set_v[z];
        assign hyst_bus[z*8 +: 8] = hyst_v[z];
    end

    thermal_event_filter u_thermal_event_filter (
        .clk (clk), .rst_n (rst_n), .shutdown (shutdown), .depth_code (depth_code),
        .smp_valid (smp_valid), .smp_bus (smp_bus), .set_bus (set_bus), .hyst_bus (hyst_bus),
        .evt_pulse (evt_pulse), .evt_dir (evt_dir), .level (level)
    );

    // behavioural reference
    int  m_run [NZ];
    bit  m_wait_hi [NZ];
    bit  m_lvl [NZ], m_pls [NZ], m_dir [NZ];
    int  vectors = 0, misses = 0, cycles = 0;
    bit  started = 0;
    string cur_req = "R8";

    function automatic int needed(input logic [1:0] c);
        if (c == 2'b00) return 1;
        if (c == 2'b01) return 2;
        if (c == 2'b10) return 4;
        return 6;
    endfunction

    always @(posedge clk) begin
        for (int z = 0; z < NZ; z++) begin
            if (!rst_n || shutdown) begin
                m_run[z] = 0; m_wait_hi[z] = 1; m_lvl[z] = 0; m_pls[z] = 0;
                if (!rst_n) m_dir[z] = 0;
            end else begin
                m_pls[z] = 0;
                if (smp_valid[z]) begin
                    int s, hi, lo;
                    bit ok;
                    s  = int'($signed(smp_v[z]));
                    hi = int'($signed(set_v[z]));
                    lo = int'($signed(hyst_v[z]));
                    ok = m_wait_hi[z] ? (s > hi) : (s < lo);
                    if (ok) begin
                        m_run[z]++;
                        if (m_run[z] >= needed(depth_code)) begin
                            m_pls[z] = 1; m_dir[z] = m_wait_hi[z]; m_lvl[z] = m_wait_hi[z];
                            m_wait_hi[z] = !m_wait_hi[z]; m_run[z] = 0;
                        end
                    end else m_run[z] = 0;
                end
            end
        end
        if (rst_n) started = 1;
    end

    always @(negedge clk) begin
        if (started && rst_n) begin
            for (int z = 0; z < NZ; z++) begin
                bit bad;
                vectors++;
                bad = (evt_pulse[z] !== m_pls[z]) || (level[z] !== m_lvl[z]) ||
                      (m_pls[z] && evt_dir[z] !== m_dir[z]);
                if (bad) begin
                    misses++;
                    $display("FAIL %s zone %0d: pulse/dir/level got %b/%b/%b expected %b/%b/%b",
                             cur_req, z, evt_pulse[z], evt_dir[z], level[z], m_pls[z], m_dir[z], m_lvl[z]);
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            misses++;
            $display("FAIL watchdog: cycles %0d expected below 20000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    task automatic rd(input logic [NZ-1:0] v, input int a, input int b, input int c);
        @(negedge clk);
        smp_valid = v; smp_v[0] = 8'(a); smp_v[1] = 8'(b); smp_v[2] = 8'(c);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            smp_valid = '0;
        end
    endtask

    initial begin
        int x;
        for (int z = 0; z < NZ; z++) begin
            smp_v[z] = 0; set_v[z] = 8'd50; hyst_v[z] = 8'd40;
        end
        set_v[1] = 8'(-10); hyst_v[1] = 8'(-20);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R8"; idle(3);

        cur_req = "R2"; depth_code = 2'b00;
        rd(3'b001, 50, 0, 0);  idle(1);
        rd(3'b001, 51, 0, 0);  idle(2);
        cur_req = "R4";
        rd(3'b001, 90, 0, 0); rd(3'b001, 45, 0, 0); rd(3'b001, 40, 0, 0);
        rd(3'b001, 39, 0, 0); idle(1); rd(3'b001, 30, 0, 0); idle(2);
        cur_req = "R5";
        rd(3'b001, 60, 0, 0); rd(3'b001, 10, 0, 0); idle(2);

        cur_req = "R1"; depth_code = 2'b01;
        rd(3'b001, 51, 0, 0); rd(3'b001, 30, 0, 0); rd(3'b001, 51, 0, 0);
        idle(2); rd(3'b001, 52, 0, 0); idle(2);
        cur_req = "R3";
        rd(3'b001, 20, 0, 0); idle(4); rd(3'b001, 20, 0, 0); idle(2);

        cur_req = "R1"; depth_code = 2'b11;
        for (int i = 0; i < 5; i++) rd(3'b001, 70, 0, 0);
        cur_req = "R3"; rd(3'b001, 50, 0, 0);
        cur_req = "R1";
        for (int i = 0; i < 6; i++) rd(3'b001, 70, 0, 0);
        idle(2);
        depth_code = 2'b10;
        for (int i = 0; i < 4; i++) rd(3'b001, 0, 0, 0);
        idle(2);

        cur_req = "R9"; depth_code = 2'b00;
        rd(3'b010, 0, -10, 0); rd(3'b010, 0, -5, 0); rd(3'b010, 0, -20, 0);
        rd(3'b010, 0, -21, 0); rd(3'b010, 0, 100, 0); rd(3'b010, 0, -128, 0); idle(2);

        cur_req = "R6";
        rd(3'b100, 0, 0, 99); rd(3'b011, 99, 99, 0); rd(3'b101, 0, 0, 0);
        rd(3'b110, 0, 0, 99); idle(2);

        cur_req = "R7"; depth_code = 2'b01;
        rd(3'b111, 99, 99, 99);
        shutdown = 1'b1;
        rd(3'b111, 99, 99, 99); rd(3'b111, 99, 99, 99); rd(3'b111, 99, 99, 99);
        shutdown = 1'b0;
        rd(3'b111, 99, 99, 99); rd(3'b111, 99, 99, 99); idle(2);
        shutdown = 1'b1; idle(2); shutdown = 1'b0; idle(1);

        cur_req = "R4";
        x = 7;
        for (int i = 0; i < 3000; i++) begin
            int a, b, c;
            x = (x * 1103515245 + 12345) & 32'h7fffffff;
            a = 35 + ((x >> 4) % 20);
            b = -25 + ((x >> 9) % 20);
            c = 35 + ((x >> 14) % 20);
            if (i % 300 == 0) depth_code = 2'((x >> 20) & 3);
            shutdown = ((x >> 24) % 97) == 0;
            rd(3'((x >> 27) & 7), a, b, c);
        end
        shutdown = 1'b0;
        idle(3);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule